// File: doc/BRIEF.md
# Bidirectional Latched/Registered Bus Transceiver

This block carries two independent data words across a boundary: one from side A to side B and one from side B to side A. Each direction has its own storage word and its own three controls: a pass-through enable, a capture strobe and a drive enable. While the pass-through enable is high, the output follows the input in the same cycle. While it is low, the output shows the stored word. The stored word changes only when the capture strobe goes from low to high.

The pads on each side are split into a data input, a data output and a drive-enable output, so the block can be synthesized; the pad ring forms the tri-state buffer. Storage is built from flip-flops on the system clock `clk`. The capture strobes are treated as ordinary inputs, synchronous to `clk`. A strobe edge is a low sample followed by a high sample on consecutive `clk` edges. The A-to-B drive enable is active high. The B-to-A drive enable is active low.

Top module: `tcv_bus_xcvr`

## Requirements
- R1: Each direction is `WIDTH` bits wide (default 18), and every bit travels independently of the others, so any bit pattern passes unaltered.
- R2: While a direction's pass-through enable is high, that direction's data output equals its data input combinationally, in the same cycle.
- R3: While the pass-through enable is low and no strobe edge occurs, the data output keeps the stored word. Changes on the data input have no effect, and neither does a strobe held steadily high or low.
- R4: A strobe edge is a strobe sampled low at one `clk` edge and high at the next. With the pass-through enable low, a strobe edge loads the data input into storage at that `clk` edge, and the output shows the loaded word from then on.
- R5: While the pass-through enable is high, storage takes the data input at every `clk` edge. When the enable falls, the output therefore keeps the last word that passed through until the next strobe edge.
- R6: If the pass-through enable is high during a strobe edge, pass-through wins: the output follows the input, and storage ends holding that input.
- R7: `b_drive_en` equals `ab_en` (active high). Toggling it changes no stored word and no data output.
- R8: `a_drive_en` is the inverse of `ba_en_n` (active low). Toggling it changes no stored word and no data output.
- R9: The two directions are independent. No control or data input of one direction affects the other direction's storage or output.
- R10: While `rst_n` is low, both stored words clear to zero. The strobe history is set to high, so a strobe that is already high when reset is released is not an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_din | input | WIDTH | Data arriving from side A |
| a_dout | output | WIDTH | Data driven toward side A |
| a_drive_en | output | 1 | Side A pad drive enable |
| b_din | input | WIDTH | Data arriving from side B |
| b_dout | output | WIDTH | Data driven toward side B |
| b_drive_en | output | 1 | Side B pad drive enable |
| ab_le | input | 1 | A-to-B pass-through enable |
| ab_strb | input | 1 | A-to-B capture strobe |
| ab_en | input | 1 | A-to-B drive enable, active high |
| ba_le | input | 1 | B-to-A pass-through enable |
| ba_strb | input | 1 | B-to-A capture strobe |
| ba_en_n | input | 1 | B-to-A drive enable, active low |

## Verification
The bench builds the block at the default width of 18. This makes all-ones and alternating patterns, and the top bit 17, part of the test, so a bit lost in either direction shows up. It covers each combination of pass-through enable and strobe level and edge, in both directions. It includes the pass-through enable falling while the input is changing, and the case of enable and strobe edge together. It also changes the drive enables between a store and a readback.

// File: rtl/tcv_pkg.sv
package tcv_pkg;
    localparam int unsigned DATA_W = 18;

    typedef enum logic {
        OE_ACT_HIGH = 1'b0,
        OE_ACT_LOW  = 1'b1
    } oe_pol_e;
endpackage

// File: rtl/tcv_edge.sv
module tcv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.prev = strb;
        rise       = strb & ~cur_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q.prev <= 1'b1;
        else        cur_q      <= nxt_d;
    end

    // R4: an edge is a single-cycle event
    a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tcv_lane.sv
module tcv_lane #(
    parameter int unsigned       WIDTH = tcv_pkg::DATA_W,
    parameter tcv_pkg::oe_pol_e  POL   = tcv_pkg::OE_ACT_HIGH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic             rise,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             drive_en
);
    typedef struct packed {
        logic [WIDTH-1:0] store;
    } lane_st_t;

    lane_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (le || rise) nxt_d.store = din;
        dout = le ? din : cur_q.store;
    end

    generate
        if (POL == tcv_pkg::OE_ACT_HIGH) begin : g_oe_hi
            assign drive_en = en;
        end else begin : g_oe_lo
            assign drive_en = ~en;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q.store <= '0;
        else        cur_q       <= nxt_d;
    end

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !rise) |=> $stable(cur_q.store));

    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && rise) |=> (cur_q.store == $past(din)));

    a_r5_track_while_open: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (cur_q.store == $past(din)));

    a_r6_open_shows_input: assert property (@(posedge clk) disable iff (!rst_n)
        (le && rise) |-> (dout == din));

    a_r7_enable_no_store_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !rise && $changed(en)) |=> $stable(cur_q.store));
endmodule

// File: rtl/tcv_bus_xcvr.sv
module tcv_bus_xcvr #(
    parameter int unsigned WIDTH = tcv_pkg::DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_din,
    output logic [WIDTH-1:0] a_dout,
    output logic             a_drive_en,
    input  logic [WIDTH-1:0] b_din,
    output logic [WIDTH-1:0] b_dout,
    output logic             b_drive_en,
    input  logic             ab_le,
    input  logic             ab_strb,
    input  logic             ab_en,
    input  logic             ba_le,
    input  logic             ba_strb,
    input  logic             ba_en_n
);
    localparam int unsigned NDIR = 2;

    logic [WIDTH-1:0] din_w  [NDIR];
    logic [WIDTH-1:0] dout_w [NDIR];
    logic             le_w   [NDIR];
    logic             strb_w [NDIR];
    logic             en_w   [NDIR];
    logic             rise_w [NDIR];
    logic             drv_w  [NDIR];

    // index 0: A to B, index 1: B to A
    assign din_w[0]  = a_din;
    assign din_w[1]  = b_din;
    assign le_w[0]   = ab_le;
    assign le_w[1]   = ba_le;
    assign strb_w[0] = ab_strb;
    assign strb_w[1] = ba_strb;
    assign en_w[0]   = ab_en;
    assign en_w[1]   = ba_en_n;

    assign b_dout     = dout_w[0];
    assign b_drive_en = drv_w[0];
    assign a_dout     = dout_w[1];
    assign a_drive_en = drv_w[1];

    generate
        for (genvar g = 0; g < NDIR; g++) begin : g_dir
            localparam tcv_pkg::oe_pol_e LPOL =
                (g == 0) ? tcv_pkg::OE_ACT_HIGH : tcv_pkg::OE_ACT_LOW;

            tcv_edge u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .strb (strb_w[g]),
                .rise (rise_w[g])
            );

            tcv_lane #(.WIDTH(WIDTH), .POL(LPOL)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .le      (le_w[g]),
                .rise    (rise_w[g]),
                .en      (en_w[g]),
                .din     (din_w[g]),
                .dout    (dout_w[g]),
                .drive_en(drv_w[g])
            );
        end
    endgenerate

    a_r7_b_enable_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ab_en) |-> b_drive_en);

    a_r8_a_enable_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ba_en_n) |-> a_drive_en);

    a_r9_ab_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !ab_strb) |=> (!ab_le -> $stable(b_dout)));
endmodule

// File: tb/tcv_bus_xcvr_tb.sv
module tcv_bus_xcvr_tb;
    localparam int unsigned W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic [W-1:0] a_dout, b_dout;
    logic         a_drive_en, b_drive_en;
    logic         ab_le = 1'b0, ab_strb = 1'b0, ab_en = 1'b0;
    logic         ba_le = 1'b0, ba_strb = 1'b0, ba_en_n = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tcv_bus_xcvr #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_din(a_din), .a_dout(a_dout), .a_drive_en(a_drive_en),
        .b_din(b_din), .b_dout(b_dout), .b_drive_en(b_drive_en),
        .ab_le(ab_le), .ab_strb(ab_strb), .ab_en(ab_en),
        .ba_le(ba_le), .ba_strb(ba_strb), .ba_en_n(ba_en_n)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock, then settle away from the edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        ab_strb = 1'b1; ba_strb = 1'b1;
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        a_din = 18'h15555; b_din = 18'h0AAAA;
        step(); step();
        chk("R10 b_dout after reset", b_dout, '0);
        chk("R10 a_dout after reset", a_dout, '0);
        chk("R7 b_drive_en off", {17'b0, b_drive_en}, 18'h0);
        chk("R8 a_drive_en off", {17'b0, a_drive_en}, 18'h0);
        ab_strb = 1'b0; ba_strb = 1'b0;
        step();
    endtask

    task automatic t_transparent();
        logic [W-1:0] pats [4] = '{18'h3FFFF, 18'h2AAAA, 18'h15555, 18'h20001};
        ab_le = 1'b1; ba_le = 1'b1;
        foreach (pats[i]) begin
            a_din = pats[i]; b_din = ~pats[i];
            settle();
            chk("R2 R1 A to B transparent", b_dout, pats[i]);
            chk("R2 R1 B to A transparent", a_dout, ~pats[i]);
            step();
        end
        ab_le = 1'b0; ba_le = 1'b0;
        step();
    endtask

    task automatic t_le_fall();
        ab_le = 1'b1; a_din = 18'h12345;
        step();
        ab_le = 1'b0; a_din = 18'h0F0F0;
        settle();
        chk("R5 value kept as enable falls", b_dout, 18'h12345);
        step();
        chk("R5 value kept next cycle", b_dout, 18'h12345);
    endtask

    task automatic t_hold();
        ab_strb = 1'b0; a_din = 18'h3C3C3;
        step();
        chk("R3 hold with strobe low", b_dout, 18'h12345);
        ab_strb = 1'b1;
        step();
        ab_strb = 1'b1; a_din = 18'h00FFF;
        step(); step();
        chk("R3 hold with strobe steady high", b_dout, 18'h3C3C3);
    endtask

    task automatic t_capture();
        ab_strb = 1'b0; a_din = 18'h11111;
        step();
        chk("R3 no capture on falling strobe", b_dout, 18'h3C3C3);
        ab_strb = 1'b1; a_din = 18'h2BEEF;
        settle();
        chk("R4 before edge old value", b_dout, 18'h3C3C3);
        step();
        chk("R4 A to B captured", b_dout, 18'h2BEEF);
        ba_strb = 1'b0; b_din = 18'h0ACE1;
        step();
        ba_strb = 1'b1;
        step();
        chk("R4 B to A captured", a_dout, 18'h0ACE1);
        ab_strb = 1'b0; ba_strb = 1'b0;
        step();
    endtask

    task automatic t_priority();
        ab_le = 1'b1; ab_strb = 1'b1; a_din = 18'h1D00D;
        settle();
        chk("R6 transparent wins at edge", b_dout, 18'h1D00D);
        step();
        ab_le = 1'b0; ab_strb = 1'b0; a_din = 18'h00000;
        settle();
        chk("R6 stored input after overlap", b_dout, 18'h1D00D);
        step();
    endtask

    task automatic t_enables();
        ab_en = 1'b1; ba_en_n = 1'b0;
        settle();
        chk("R7 b_drive_en on", {17'b0, b_drive_en}, 18'h1);
        chk("R8 a_drive_en on", {17'b0, a_drive_en}, 18'h1);
        step();
        ab_en = 1'b0; ba_en_n = 1'b1;
        step();
        ab_en = 1'b1; ba_en_n = 1'b0;
        step();
        chk("R7 store intact after enable toggle", b_dout, 18'h1D00D);
        chk("R8 store intact after enable toggle", a_dout, 18'h0ACE1);
    endtask

    task automatic t_independent();
        ab_strb = 1'b0; a_din = 18'h33333; b_din = 18'h1F1F1;
        step();
        ab_strb = 1'b1; ab_le = 1'b1;
        step();
        chk("R9 B to A unaffected by A side", a_dout, 18'h0ACE1);
        ab_le = 1'b0; ab_strb = 1'b0;
        ba_le = 1'b1; b_din = 18'h27272;
        step();
        ba_le = 1'b0;
        step();
        chk("R9 A to B unaffected by B side", b_dout, 18'h33333);
        chk("R9 B to A own pass-through", a_dout, 18'h27272);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_le_fall();
        t_hold();
        t_capture();
        t_priority();
        t_enables();
        t_independent();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule